// File: doc/BRIEF.md
# Gen2 Speed-Change Stall Recovery Monitor

This block sits beside a PCI Express link controller and runs a one-shot health check each time it is asked. It looks for one failure: after a request to move to the second-generation rate, the training state machine sits in the receiver-lock step of recovery while the PHY receiver never reports valid data. When the block sees that failure, it nudges the PHY receiver. It forces the receive-data-enable and receive-PLL-enable override bits on, waits a programmable hold time of about 2 ms, and then releases them. It does not reset the whole PHY.

PHY registers are reached through a simple request/acknowledge register port, one access at a time. Each modification is a read followed by a write of the altered value, so all other override bits are preserved. Every check ends with a one-cycle completion pulse and a two-bit status. The status stays valid until the next check ends. Training logic is outside the block. The only training inputs it takes are the 6-bit training state and a link-down debug indication.

Top module: `gen2_stall_recovery`

## Requirements
- R1: When a check is requested while `link_down` is high, the check finishes on the next clock edge with status RETRY (code 1), and no PHY register access takes place.
- R2: Otherwise the first access is a read of PHY address 0x100D. If bit 0 of the returned data is set, the check ends with status OK (code 0) and no further access. All other bits of that word are ignored.
- R3: If bit 0 is clear and the training state, sampled when that read completes, is not 0x0D, the check ends with status OK and no further access.
- R4: If bit 0 is clear and the training state is 0x0D, the block reads PHY address 0x1005 and then writes back the value read with bits 5 and 3 set. All other bits are kept.
- R5: After the hold, the block reads address 0x1005 again and writes back the value read with bits 5 and 3 cleared. All other bits are kept. The check then ends with status RECOVERED (code 2).
- R6: The second read of 0x1005 does not begin until at least HOLD_CYCLES clocks after the first write was acknowledged.
- R7: An access that is not acknowledged within ACC_TIMEOUT cycles is withdrawn. The check ends with status ERROR (code 3) and no further access. The address stays stable while a request is pending.
- R8: A check request that arrives while a check is in progress has no effect: it produces no extra completion.
- R9: `chk_done` is high for one cycle per completed check, and `chk_status` changes only in that cycle.
- R10: After reset, `chk_done` and `phy_req` are low and `chk_status` is OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | Start a stall check (sampled when idle) |
| link_down | input | 1 | Link-down debug indication |
| train_state | input | 6 | Current link training state code |
| phy_req | output | 1 | PHY register access request, held until acknowledged or timed out |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | One-cycle access completion |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| chk_done | output | 1 | One-cycle pulse when a check finishes |
| chk_status | output | 2 | 0 OK, 1 RETRY, 2 RECOVERED, 3 ERROR |

## Verification
A sequencer stuck in the wrong state shows up at the ports in one of three ways: an access to an unexpected address, a wrong number of accesses, or a completion that never comes. The bench counts and logs every access, so a mistake shows within the same check. A wrong mask or bit position shows up as a bad override value in the first write of a recovery. A short hold counter shows up as a reduced gap between the first write acknowledge and the second read.

// File: rtl/g2sr_pkg.sv
package g2sr_pkg;

    localparam int unsigned PHY_AW  = 16;
    localparam int unsigned PHY_DW  = 16;
    localparam int unsigned TRAIN_W = 6;

    localparam logic [PHY_AW-1:0] RXSTAT_ADDR = 16'h100D;
    localparam logic [PHY_AW-1:0] RXOVRD_ADDR = 16'h1005;

    localparam int unsigned RXVALID_BIT  = 0;
    localparam int unsigned OVRD_DEN_BIT = 5;
    localparam int unsigned OVRD_PLL_BIT = 3;

    localparam logic [TRAIN_W-1:0] TRAIN_RCVRLOCK = 6'h0D;

    typedef enum logic [1:0] {
        CHK_OK        = 2'd0,
        CHK_RETRY     = 2'd1,
        CHK_RECOVERED = 2'd2,
        CHK_ERROR     = 2'd3
    } chk_status_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RXSTAT,
        SQ_OVR_RD1,
        SQ_OVR_WR1,
        SQ_HOLD,
        SQ_OVR_RD2,
        SQ_OVR_WR2
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [PHY_AW-1:0] addr;
        logic [PHY_DW-1:0] wdata;
    } phy_cmd_t;

    function automatic logic [PHY_DW-1:0] ovrd_mask();
        logic [PHY_DW-1:0] m;
        m = '0;
        m[OVRD_DEN_BIT] = 1'b1;
        m[OVRD_PLL_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [PHY_DW-1:0] ovrd_apply(input logic [PHY_DW-1:0] v,
                                                     input logic set_bits);
        return set_bits ? (v | ovrd_mask()) : (v & ~ovrd_mask());
    endfunction

    function automatic phy_cmd_t mk_read(input logic [PHY_AW-1:0] a);
        phy_cmd_t c;
        c.we    = 1'b0;
        c.addr  = a;
        c.wdata = '0;
        return c;
    endfunction

    function automatic phy_cmd_t mk_write(input logic [PHY_AW-1:0] a,
                                          input logic [PHY_DW-1:0] d);
        phy_cmd_t c;
        c.we    = 1'b1;
        c.addr  = a;
        c.wdata = d;
        return c;
    endfunction

endpackage

// File: rtl/g2sr_phy_access.sv
module g2sr_phy_access
    import g2sr_pkg::*;
#(
    parameter int unsigned TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  phy_cmd_t          cmd,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [PHY_DW-1:0] phy_rdata,
    output logic              done,
    output logic              tout,
    output logic [PHY_DW-1:0] rdata
);

    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic          req_q;
    phy_cmd_t      cmd_q;
    logic [CW-1:0] wait_q;
    logic          done_q;
    logic          tout_q;
    logic [PHY_DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            cmd_q   <= '0;
            wait_q  <= '0;
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            tout_q <= 1'b0;
            if (req_q) begin
                if (phy_ack) begin
                    req_q   <= 1'b0;
                    done_q  <= 1'b1;
                    rdata_q <= phy_rdata;
                end else if (wait_q == LAST) begin
                    req_q  <= 1'b0;
                    tout_q <= 1'b1;
                end else begin
                    wait_q <= wait_q + 1'b1;
                end
            end else if (start) begin
                req_q  <= 1'b1;
                cmd_q  <= cmd;
                wait_q <= '0;
            end
        end
    end

    assign phy_req   = req_q;
    assign phy_we    = cmd_q.we;
    assign phy_addr  = cmd_q.addr;
    assign phy_wdata = cmd_q.wdata;
    assign done      = done_q;
    assign tout      = tout_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/g2sr_hold_timer.sv
module g2sr_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    localparam int unsigned TW = $clog2(HOLD_CYCLES + 1);
    localparam logic [TW-1:0] INIT = TW'(HOLD_CYCLES - 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;
    logic          exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (load) begin
                cnt_q <= INIT;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign expired = exp_q;

endmodule

// File: rtl/g2sr_seq.sv
module g2sr_seq
    import g2sr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_req,
    input  logic               link_down,
    input  logic [TRAIN_W-1:0] train_state,
    input  logic               acc_done,
    input  logic               acc_tout,
    input  logic [PHY_DW-1:0]  acc_rdata,
    output logic               acc_start,
    output phy_cmd_t           acc_cmd,
    output logic               hold_load,
    input  logic               hold_exp,
    output logic               chk_done,
    output chk_status_e        chk_status,
    output logic               busy
);

    seq_state_e  st_q, st_d;
    logic        fin;
    chk_status_e fin_st;
    logic        done_q;
    chk_status_e status_q;
    logic        in_access;

    assign in_access = (st_q == SQ_RXSTAT) || (st_q == SQ_OVR_RD1) ||
                       (st_q == SQ_OVR_WR1) || (st_q == SQ_OVR_RD2) ||
                       (st_q == SQ_OVR_WR2);

    always_comb begin
        st_d      = st_q;
        acc_start = 1'b0;
        acc_cmd   = '0;
        hold_load = 1'b0;
        fin       = 1'b0;
        fin_st    = CHK_OK;
        if (in_access && acc_tout) begin
            fin    = 1'b1;
            fin_st = CHK_ERROR;
            st_d   = SQ_IDLE;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (chk_req) begin
                        if (link_down) begin
                            fin    = 1'b1;
                            fin_st = CHK_RETRY;
                        end else begin
                            acc_start = 1'b1;
                            acc_cmd   = mk_read(RXSTAT_ADDR);
                            st_d      = SQ_RXSTAT;
                        end
                    end
                end
                SQ_RXSTAT: begin
                    if (acc_done) begin
                        if (!acc_rdata[RXVALID_BIT] && train_state == TRAIN_RCVRLOCK) begin
                            acc_start = 1'b1;
                            acc_cmd   = mk_read(RXOVRD_ADDR);
                            st_d      = SQ_OVR_RD1;
                        end else begin
                            fin    = 1'b1;
                            fin_st = CHK_OK;
                            st_d   = SQ_IDLE;
                        end
                    end
                end
                SQ_OVR_RD1: begin
                    if (acc_done) begin
                        acc_start = 1'b1;
                        acc_cmd   = mk_write(RXOVRD_ADDR, ovrd_apply(acc_rdata, 1'b1));
                        st_d      = SQ_OVR_WR1;
                    end
                end
                SQ_OVR_WR1: begin
                    if (acc_done) begin
                        hold_load = 1'b1;
                        st_d      = SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (hold_exp) begin
                        acc_start = 1'b1;
                        acc_cmd   = mk_read(RXOVRD_ADDR);
                        st_d      = SQ_OVR_RD2;
                    end
                end
                SQ_OVR_RD2: begin
                    if (acc_done) begin
                        acc_start = 1'b1;
                        acc_cmd   = mk_write(RXOVRD_ADDR, ovrd_apply(acc_rdata, 1'b0));
                        st_d      = SQ_OVR_WR2;
                    end
                end
                SQ_OVR_WR2: begin
                    if (acc_done) begin
                        fin    = 1'b1;
                        fin_st = CHK_RECOVERED;
                        st_d   = SQ_IDLE;
                    end
                end
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            done_q   <= 1'b0;
            status_q <= CHK_OK;
        end else begin
            st_q   <= st_d;
            done_q <= fin;
            if (fin) begin
                status_q <= fin_st;
            end
        end
    end

    assign chk_done   = done_q;
    assign chk_status = status_q;
    assign busy       = (st_q != SQ_IDLE);

endmodule

// File: rtl/gen2_stall_recovery.sv
module gen2_stall_recovery
    import g2sr_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 100000,
    parameter int unsigned ACC_TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        chk_req,
    input  logic        link_down,
    input  logic [5:0]  train_state,
    output logic        phy_req,
    output logic        phy_we,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata,
    output logic        chk_done,
    output logic [1:0]  chk_status
);

    logic              acc_start;
    phy_cmd_t          acc_cmd;
    logic              acc_done;
    logic              acc_tout;
    logic [PHY_DW-1:0] acc_rdata;
    logic              hold_load;
    logic              hold_exp;
    chk_status_e       status_e;
    logic              busy;

    g2sr_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .chk_req     (chk_req),
        .link_down   (link_down),
        .train_state (train_state),
        .acc_done    (acc_done),
        .acc_tout    (acc_tout),
        .acc_rdata   (acc_rdata),
        .acc_start   (acc_start),
        .acc_cmd     (acc_cmd),
        .hold_load   (hold_load),
        .hold_exp    (hold_exp),
        .chk_done    (chk_done),
        .chk_status  (status_e),
        .busy        (busy)
    );

    g2sr_phy_access #(.TIMEOUT(ACC_TIMEOUT)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .start     (acc_start),
        .cmd       (acc_cmd),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .done      (acc_done),
        .tout      (acc_tout),
        .rdata     (acc_rdata)
    );

    g2sr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (hold_load),
        .expired (hold_exp)
    );

    assign chk_status = status_e;

endmodule

// File: rtl/gen2_stall_recovery_chk.sv
module gen2_stall_recovery_chk #(
    parameter int unsigned ACC_TIMEOUT = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        chk_req,
    input logic        link_down,
    input logic        phy_req,
    input logic        phy_we,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic        phy_ack,
    input logic        chk_done,
    input logic [1:0]  chk_status,
    input logic        busy
);

    localparam int unsigned PW = $clog2(ACC_TIMEOUT + 2) + 1;
    logic [PW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst || !phy_req || phy_ack) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + 1'b1;
        end
    end

    p_retry_r1: assert property (@(posedge clk) disable iff (rst)
        (chk_req && link_down && !busy) |=> (chk_done && chk_status == 2'd1 && !phy_req));

    p_ovr_write_r4: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_we) |-> (phy_addr == 16'h1005 && phy_wdata[5] == phy_wdata[3]));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=> (!phy_req || $stable(phy_addr)));

    p_acc_bound_r7: assert property (@(posedge clk) disable iff (rst)
        pend_q <= PW'(ACC_TIMEOUT));

    p_idle_end_r7: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> !phy_req);

    p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !chk_done |-> $stable(chk_status));

endmodule

bind gen2_stall_recovery gen2_stall_recovery_chk #(.ACC_TIMEOUT(ACC_TIMEOUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chk_req    (chk_req),
    .link_down  (link_down),
    .phy_req    (phy_req),
    .phy_we     (phy_we),
    .phy_addr   (phy_addr),
    .phy_wdata  (phy_wdata),
    .phy_ack    (phy_ack),
    .chk_done   (chk_done),
    .chk_status (chk_status),
    .busy       (busy)
);

// File: tb/test_gen2_stall_recovery.sv
module test_gen2_stall_recovery;

    localparam int HOLD = 40;
    localparam int TOUT = 16;
    localparam int LAT  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_req = 1'b0;
    logic        link_down = 1'b0;
    logic [5:0]  train_state = 6'h00;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = 16'h0000;
    logic        chk_done;
    logic [1:0]  chk_status;

    gen2_stall_recovery #(.HOLD_CYCLES(HOLD), .ACC_TIMEOUT(TOUT)) i_gen2_stall_recovery (
        .clk(clk), .rst(rst), .chk_req(chk_req), .link_down(link_down),
        .train_state(train_state), .phy_req(phy_req), .phy_we(phy_we),
        .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
        .phy_rdata(phy_rdata), .chk_done(chk_done), .chk_status(chk_status)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;
    int ndone = 0;

    // PHY register model
    logic [15:0] rxstat_val = 16'h0000;
    logic [15:0] ovr_val = 16'h0000;
    int resp_limit = 99;
    int acc_n = 0;
    int wn = 0;
    int lat_cnt = 0;
    logic [15:0] wlog [0:3];
    logic [15:0] alog [0:7];
    int ack_cyc [0:7];

    always @(negedge clk) begin
        if (rst) begin
            phy_ack = 1'b0;
            lat_cnt = 0;
        end else if (phy_ack) begin
            phy_ack = 1'b0;
        end else if (phy_req && acc_n < resp_limit) begin
            if (lat_cnt == LAT) begin
                lat_cnt = 0;
                phy_ack = 1'b1;
                if (acc_n < 8) begin
                    alog[acc_n] = phy_addr;
                    ack_cyc[acc_n] = cyc;
                end
                if (phy_we) begin
                    if (wn < 4) wlog[wn] = phy_wdata;
                    wn = wn + 1;
                    if (phy_addr == 16'h1005) ovr_val = phy_wdata;
                end else begin
                    phy_rdata = (phy_addr == 16'h100D) ? rxstat_val :
                                (phy_addr == 16'h1005) ? ovr_val : 16'hDEAD;
                end
                acc_n = acc_n + 1;
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0]  st;
        int          nacc;
        int          nwr;
        logic [15:0] w0;
        logic [15:0] w1;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // monitor: pops expectations as completions appear
    always @(negedge clk) begin
        if (!rst && chk_done) begin
            ndone++;
            if (sb_q.size() == 0) begin
                chk("R8 unexpected completion", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " status (R9)"}, 32'(chk_status), 32'(e.st));
                chk({e.tag, " access count"}, 32'(acc_n), 32'(e.nacc));
                chk({e.tag, " write count"}, 32'(wn), 32'(e.nwr));
                chk({e.tag, " req idle at end (R7)"}, 32'(phy_req), 32'd0);
                if (e.nwr > 0) chk({e.tag, " set write (R4)"}, 32'(wlog[0]), 32'(e.w0));
                if (e.nwr > 1) chk({e.tag, " clear write (R5)"}, 32'(wlog[1]), 32'(e.w1));
            end
        end
    end

    task automatic run_check(input logic lnk, input logic [5:0] ts, input logic [15:0] rxv,
                             input logic [15:0] ovr, input int rl, input exp_t e);
        int n0;
        int w;
        @(negedge clk);
        link_down   = lnk;
        train_state = ts;
        rxstat_val  = rxv;
        ovr_val     = ovr;
        resp_limit  = rl;
        acc_n       = 0;
        wn          = 0;
        sb_q.push_back(e);
        n0 = ndone;
        chk_req = 1'b1;
        @(negedge clk);
        chk_req = 1'b0;
        w = 0;
        while (ndone == n0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 3000) chk({e.tag, " no completion"}, 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    function automatic exp_t mk(input logic [1:0] st, input int na, input int nw,
                                input logic [15:0] w0, input logic [15:0] w1, input string tag);
        exp_t e;
        e.st = st; e.nacc = na; e.nwr = nw; e.w0 = w0; e.w1 = w1; e.tag = tag;
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int d;
        int nd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 done after reset", 32'(chk_done), 32'd0);
        chk("R10 req after reset", 32'(phy_req), 32'd0);
        chk("R10 status after reset", 32'(chk_status), 32'd0);

        // R1 link down: retry, no access, even in stall state
        run_check(1'b1, 6'h0D, 16'h0000, 16'h0000, 99, mk(2'd1, 0, 0, 0, 0, "R1 link down"));

        // R2 receiver valid set: OK after one read of 0x100D
        run_check(1'b0, 6'h0D, 16'h0001, 16'h0000, 99, mk(2'd0, 1, 0, 0, 0, "R2 rx valid"));
        chk("R2 first address", 32'(alog[0]), 32'h100D);

        // R3 training state not the stall code
        run_check(1'b0, 6'h0C, 16'h0000, 16'h0000, 99, mk(2'd0, 1, 0, 0, 0, "R3 state 0C"));
        run_check(1'b0, 6'h2D, 16'h0000, 16'h0000, 99, mk(2'd0, 1, 0, 0, 0, "R3 state 2D"));

        // R4 R5 R6 recovery from a clear register
        run_check(1'b0, 6'h0D, 16'h0000, 16'h0000, 99,
                  mk(2'd2, 5, 2, 16'h0028, 16'h0000, "R5 recover zero"));
        chk("R4 ovr read address", 32'(alog[1]), 32'h1005);
        chk("R5 second read address", 32'(alog[3]), 32'h1005);
        d = ack_cyc[3] - ack_cyc[2];
        chk("R6 hold gap in range", 32'(d >= HOLD && d <= HOLD + LAT + 8), 32'd1);

        // R4 R5 other bits preserved
        run_check(1'b0, 6'h0D, 16'h0000, 16'h8101, 99,
                  mk(2'd2, 5, 2, 16'h8129, 16'h8101, "R4 keep bits"));
        run_check(1'b0, 6'h0D, 16'h0000, 16'h0028, 99,
                  mk(2'd2, 5, 2, 16'h0028, 16'h0000, "R5 preset bits"));

        // R2 only bit 0 of the status word matters
        run_check(1'b0, 6'h0D, 16'hFFFE, 16'h0400, 99,
                  mk(2'd2, 5, 2, 16'h0428, 16'h0400, "R2 upper bits ignored"));

        // R7 timeouts
        run_check(1'b0, 6'h0D, 16'h0000, 16'h0000, 0, mk(2'd3, 0, 0, 0, 0, "R7 first access"));
        run_check(1'b0, 6'h0D, 16'h0000, 16'h0000, 1, mk(2'd3, 1, 0, 0, 0, "R7 ovr read"));
        run_check(1'b0, 6'h0D, 16'h0000, 16'h0000, 3,
                  mk(2'd3, 3, 1, 16'h0028, 0, "R7 after hold"));

        // R8 request during a running check is ignored
        nd0 = ndone;
        fork
            begin
                repeat (20) @(negedge clk);
                chk_req = 1'b1;
                @(negedge clk);
                chk_req = 1'b0;
            end
        join_none
        run_check(1'b0, 6'h0D, 16'h0000, 16'h0010, 99,
                  mk(2'd2, 5, 2, 16'h0038, 16'h0010, "R8 busy recover"));
        repeat (10) @(negedge clk);
        chk("R8 single completion", 32'(ndone - nd0), 32'd1);
        chk("R9 done pulse low", 32'(chk_done), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule